// File: doc/BRIEF.md
# ARX Keyed Permutation Round Engine

This block is an iterative engine for a keyed permutation over sixteen words arranged as a 4×4 array. It is the core of an add-rotate-XOR hash compression function. A start handshake loads the state. The engine then runs a fixed number of rounds and holds the state internally between them. Each round takes two clock cycles. The first cycle is a column step and the second is a diagonal step. Both steps use the same four mixing units. For the diagonal step, row i is rotated left by i word positions before the mixing units and rotated back afterwards.

Key words come from an external supplier. The engine drives a request made of a selection index (the round number modulo 10) and a phase bit. From these the supplier presents sixteen pre-combined key words for the current round. Word width is a parameter. 32-bit words run 14 rounds with rotate amounts 16/12/8/7. 64-bit words run 16 rounds with rotate amounts 32/25/16/11. Padding, chaining-value setup and storage of the tables are left to the surrounding logic.

Top module: `arx_perm_core`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the outputs are as follows: `start_ready` is 1, `busy` is 0, `done` is 0, `key_round` is 0 and `key_phase` is 0.
- R2: A start is accepted on a rising edge where both `start_valid` and `start_ready` are 1. That edge loads `state_in` (word i at bits [i*W +: W]). `start_ready` is 0 for as long as `busy` is 1.
- R3: In a column cycle (`key_phase`=0), mixing unit j (j=0..3) processes words (vj, v4+j, v8+j, v12+j). Its first key is key word 2j and its second key is key word 2j+1. Key word n sits at bits [n*W +: W] of `key_in`.
- R4: In a diagonal cycle (`key_phase`=1), mixing unit j processes words (vj, v4+(j+1)%4, v8+(j+2)%4, v12+(j+3)%4) with key words 8+2j and 9+2j. The result equals rotating row i left by i, running a column step, and rotating row i right by i.
- R5: The mixing function G(a,b,c,d) runs these eight operations in order, with additions modulo 2^W: a=a+b+k0; d=rotr(d^a,α); c=c+d; b=rotr(b^c,β); a=a+b+k1; d=rotr(d^a,γ); c=c+d; b=rotr(b^c,δ). For W=32, α,β,γ,δ = 16,12,8,7.
- R6: Every round takes exactly two cycles. With W=32 there are 14 rounds, so `done` rises exactly 28 cycles after the accepting edge.
- R7: While busy, `key_phase` goes 0 then 1 within each round. `key_round` equals the round number modulo 10. It advances after each diagonal cycle and wraps from 9 to 0.
- R8: `done` is a single-cycle pulse. Once it rises, `state_out` holds the final state unchanged until the next accepted start.
- R9: `start_valid` asserted while busy has no effect: the run continues and its final state is unaltered.
- R10: With W=64, the rotate amounts are 32,25,16,11 and there are 16 rounds, so `done` rises exactly 32 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_valid | input | 1 | Request to load a new state and run |
| start_ready | output | 1 | High when idle and able to accept a start |
| state_in | input | 16*WORD_W | Initial state, word i at bits [i*W +: W] |
| key_in | input | 16*WORD_W | Combined key words for the current round |
| key_round | output | 4 | Selection index, round number modulo 10 |
| key_phase | output | 1 | 0 for the column cycle, 1 for the diagonal cycle |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse after the final round |
| state_out | output | 16*WORD_W | Current state; final result after done |

## Verification
The bench goes after several corner cases:
- The wrap of the selection index from 9 back to 0 in round 10. A design that failed to wrap would ask for key words from a table entry that does not exist.
- The diagonal mapping. A wrong row-rotation direction would mix the anti-diagonals. The bench catches this both against its direct-index model and in the final state.
- Exact completion latency. An off-by-one round counter would run 13 or 15 rounds.
- A start pulse injected mid-run. It must be ignored, where a faulty design would reload the state.
- Output stability after done. Stale writes would corrupt the result.
- Both word widths, each checked against its own rotate amounts. Swapped constants would change every output word.

// File: rtl/arx_perm_pkg.sv
package arx_perm_pkg;
   localparam int unsigned NUM_WORDS    = 16;
   localparam int unsigned ROW_LEN      = 4;
   localparam int unsigned SIGMA_PERIOD = 10;
   localparam int unsigned SIGMA_W      = 4;

   function automatic int unsigned rounds_for(input int unsigned w);
      return (w == 64) ? 16 : 14;
   endfunction

   // stage 0..3 -> first d rotate, first b rotate, second d rotate, second b rotate
   function automatic int unsigned rot_amt(input int unsigned w, input int unsigned stage);
      int unsigned r;
      case (stage)
         0:       r = (w == 64) ? 32 : 16;
         1:       r = (w == 64) ? 25 : 12;
         2:       r = (w == 64) ? 16 : 8;
         default: r = (w == 64) ? 11 : 7;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/arx_gmix.sv
module arx_gmix #(
   parameter int unsigned W  = 32,
   parameter int unsigned RA = 16,
   parameter int unsigned RB = 12,
   parameter int unsigned RC = 8,
   parameter int unsigned RD = 7
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   input  logic [W-1:0] d_i,
   input  logic [W-1:0] k0_i,
   input  logic [W-1:0] k1_i,
   output logic [W-1:0] a_o,
   output logic [W-1:0] b_o,
   output logic [W-1:0] c_o,
   output logic [W-1:0] d_o
);
   if (RA == 0 || RA >= W || RB == 0 || RB >= W ||
       RC == 0 || RC >= W || RD == 0 || RD >= W) begin : g_bad_rot
      $error("arx_gmix: rotate amounts must lie in 1..W-1");
   end

   function automatic logic [W-1:0] rotr(input logic [W-1:0] x, input int unsigned n);
      return (x >> n) | (x << (W - n));
   endfunction

   logic [W-1:0] a1, b1, c1, d1;
   logic [W-1:0] a2, b2, c2, d2;

   // first half: key word k0, rotates RA then RB
   assign a1 = a_i + b_i + k0_i;
   assign d1 = rotr(d_i ^ a1, RA);
   assign c1 = c_i + d1;
   assign b1 = rotr(b_i ^ c1, RB);
   // second half: key word k1, rotates RC then RD
   assign a2 = a1 + b1 + k1_i;
   assign d2 = rotr(d1 ^ a2, RC);
   assign c2 = c1 + d2;
   assign b2 = rotr(b1 ^ c2, RD);

   assign a_o = a2;
   assign b_o = b2;
   assign c_o = c2;
   assign d_o = d2;
endmodule

// File: rtl/arx_row_rot.sv
module arx_row_rot
   import arx_perm_pkg::*;
#(
   parameter int unsigned W        = 32,
   parameter bit          DIR_LEFT = 1'b1
) (
   input  logic [NUM_WORDS*W-1:0] st_i,
   output logic [NUM_WORDS*W-1:0] st_o
);
   // row r is shifted by r word positions; left: out[c] = in[(c+r)%4]
   for (genvar r = 0; r < ROW_LEN; r++) begin : g_row
      for (genvar c = 0; c < ROW_LEN; c++) begin : g_col
         localparam int unsigned SRC = DIR_LEFT ? ((c + r) % ROW_LEN)
                                                : ((c + ROW_LEN - r) % ROW_LEN);
         assign st_o[(r*ROW_LEN + c)*W +: W] = st_i[(r*ROW_LEN + SRC)*W +: W];
      end
   end
endmodule

// File: rtl/arx_col_step.sv
module arx_col_step
   import arx_perm_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [NUM_WORDS*W-1:0]   st_i,
   input  logic [NUM_WORDS/2*W-1:0] key_i,
   output logic [NUM_WORDS*W-1:0]   st_o
);
   localparam int unsigned RA = rot_amt(W, 0);
   localparam int unsigned RB = rot_amt(W, 1);
   localparam int unsigned RC = rot_amt(W, 2);
   localparam int unsigned RD = rot_amt(W, 3);

   for (genvar j = 0; j < ROW_LEN; j++) begin : g_mix
      arx_gmix #(.W(W), .RA(RA), .RB(RB), .RC(RC), .RD(RD)) mix_i (
         .a_i  (st_i[(0*ROW_LEN + j)*W +: W]),
         .b_i  (st_i[(1*ROW_LEN + j)*W +: W]),
         .c_i  (st_i[(2*ROW_LEN + j)*W +: W]),
         .d_i  (st_i[(3*ROW_LEN + j)*W +: W]),
         .k0_i (key_i[(2*j)*W +: W]),
         .k1_i (key_i[(2*j + 1)*W +: W]),
         .a_o  (st_o[(0*ROW_LEN + j)*W +: W]),
         .b_o  (st_o[(1*ROW_LEN + j)*W +: W]),
         .c_o  (st_o[(2*ROW_LEN + j)*W +: W]),
         .d_o  (st_o[(3*ROW_LEN + j)*W +: W])
      );
   end
endmodule

// File: rtl/arx_round_dp.sv
module arx_round_dp
   import arx_perm_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [NUM_WORDS*W-1:0] st_i,
   input  logic [NUM_WORDS*W-1:0] key_i,
   input  logic                   diag_i,
   output logic [NUM_WORDS*W-1:0] st_o
);
   localparam int unsigned HALF_BITS = NUM_WORDS / 2 * W;

   logic [NUM_WORDS*W-1:0] st_rot, mix_in, mix_out, st_unrot;
   logic [HALF_BITS-1:0]   key_sel;

   arx_row_rot #(.W(W), .DIR_LEFT(1'b1)) rot_l_i (.st_i(st_i), .st_o(st_rot));

   assign mix_in  = diag_i ? st_rot : st_i;
   assign key_sel = diag_i ? key_i[NUM_WORDS*W-1:HALF_BITS] : key_i[HALF_BITS-1:0];

   arx_col_step #(.W(W)) col_i (.st_i(mix_in), .key_i(key_sel), .st_o(mix_out));

   arx_row_rot #(.W(W), .DIR_LEFT(1'b0)) rot_r_i (.st_i(mix_out), .st_o(st_unrot));

   assign st_o = diag_i ? st_unrot : mix_out;
endmodule

// File: rtl/arx_perm_ctrl.sv
module arx_perm_ctrl
   import arx_perm_pkg::*;
#(
   parameter int unsigned NUM_ROUNDS = 14
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start_valid_i,
   output logic               start_ready_o,
   output logic               load_o,
   output logic               step_o,
   output logic               phase_o,
   output logic [SIGMA_W-1:0] sigma_o,
   output logic               busy_o,
   output logic               done_o
);
   localparam int unsigned RND_W = (NUM_ROUNDS > 2) ? $clog2(NUM_ROUNDS) : 1;

   if (NUM_ROUNDS < 1) begin : g_bad_rounds
      $error("arx_perm_ctrl: NUM_ROUNDS must be at least 1");
   end

   logic               busy_q, done_q, phase_q;
   logic [RND_W-1:0]   rnd_q;
   logic [SIGMA_W-1:0] sig_q;
   logic               accept, last_round, sig_wrap;

   assign accept     = start_valid_i && !busy_q;
   assign last_round = (rnd_q == RND_W'(NUM_ROUNDS - 1));
   assign sig_wrap   = (sig_q == SIGMA_W'(SIGMA_PERIOD - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         phase_q <= 1'b0;
         rnd_q   <= '0;
         sig_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            rnd_q   <= '0;
            sig_q   <= '0;
         end else if (busy_q) begin
            if (!phase_q) begin
               phase_q <= 1'b1;
            end else begin
               phase_q <= 1'b0;
               sig_q   <= sig_wrap ? '0 : sig_q + 1'b1;
               if (last_round) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  rnd_q  <= '0;
               end else begin
                  rnd_q <= rnd_q + 1'b1;
               end
            end
         end
      end
   end

   assign start_ready_o = !busy_q;
   assign load_o        = accept;
   assign step_o        = busy_q;
   assign phase_o       = phase_q;
   assign sigma_o       = sig_q;
   assign busy_o        = busy_q;
   assign done_o        = done_q;
endmodule

// File: rtl/arx_perm_core.sv
module arx_perm_core
   import arx_perm_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        start_valid,
   output logic                        start_ready,
   input  logic [NUM_WORDS*WORD_W-1:0] state_in,
   input  logic [NUM_WORDS*WORD_W-1:0] key_in,
   output logic [SIGMA_W-1:0]          key_round,
   output logic                        key_phase,
   output logic                        busy,
   output logic                        done,
   output logic [NUM_WORDS*WORD_W-1:0] state_out
);
   localparam int unsigned NUM_ROUNDS = rounds_for(WORD_W);
   localparam int unsigned ST_BITS    = NUM_WORDS * WORD_W;

   if (!(WORD_W == 32 || WORD_W == 64)) begin : g_bad_width
      $error("arx_perm_core: WORD_W must be 32 or 64");
   end

   logic               load, step, phase;
   logic [ST_BITS-1:0] st_q, st_next;

   arx_perm_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) ctrl_i (
      .clk           (clk),
      .rst           (rst),
      .start_valid_i (start_valid),
      .start_ready_o (start_ready),
      .load_o        (load),
      .step_o        (step),
      .phase_o       (phase),
      .sigma_o       (key_round),
      .busy_o        (busy),
      .done_o        (done)
   );

   arx_round_dp #(.W(WORD_W)) dp_i (
      .st_i   (st_q),
      .key_i  (key_in),
      .diag_i (phase),
      .st_o   (st_next)
   );

   always_ff @(posedge clk) begin
      if (rst)       st_q <= '0;
      else if (load) st_q <= state_in;
      else if (step) st_q <= st_next;
   end

   assign key_phase = phase;
   assign state_out = st_q;
endmodule

// File: rtl/arx_perm_chk.sv
module arx_perm_chk
   import arx_perm_pkg::*;
#(
   parameter int unsigned W          = 32,
   parameter int unsigned NUM_ROUNDS = 14
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   start_valid,
   input logic                   start_ready,
   input logic [SIGMA_W-1:0]     key_round,
   input logic                   key_phase,
   input logic                   busy,
   input logic                   done,
   input logic [NUM_WORDS*W-1:0] state_out
);
   logic [15:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst)                             run_cnt <= '0;
      else if (start_valid && start_ready) run_cnt <= '0;
      else if (busy)                       run_cnt <= run_cnt + 1'b1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (!busy && !done && start_ready && key_round == '0 && !key_phase)); // R1

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
      busy |-> !start_ready); // R2

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      done |-> (run_cnt == 16'(2 * NUM_ROUNDS))); // R6

   AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      (busy && !key_phase) |=> (busy && key_phase)); // R7

   AST_SIGMA_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (busy && key_phase) |=> (!key_phase &&
         key_round == (($past(key_round) == SIGMA_W'(SIGMA_PERIOD - 1)) ? '0 : $past(key_round) + 1'b1))); // R7

   AST_SIGMA_RANGE: assert property (@(posedge clk) disable iff (rst)
      key_round < SIGMA_W'(SIGMA_PERIOD)); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!busy && !(start_valid && start_ready)) |=> $stable(state_out)); // R8
endmodule

bind arx_perm_core arx_perm_chk #(.W(WORD_W), .NUM_ROUNDS(NUM_ROUNDS)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .start_valid (start_valid),
   .start_ready (start_ready),
   .key_round   (key_round),
   .key_phase   (key_phase),
   .busy        (busy),
   .done        (done),
   .state_out   (state_out)
);

// File: tb/arx_perm_core_tb_top.sv
module arx_perm_core_tb_top;
   typedef logic [63:0] st_t [16];

   logic clk = 1'b0;
   always #5ns clk = ~clk;

   logic          rst;
   logic          sv32, sv64;
   logic [511:0]  sin32, key32, sout32;
   logic [1023:0] sin64, key64, sout64;
   logic          rdy32, rdy64, busy32, busy64, done32, done64, kp32, kp64;
   logic [3:0]    kr32, kr64;
   st_t           kt [10];
   int            n_tests = 0;
   int            n_fail  = 0;

   arx_perm_core #(.WORD_W(32)) dut_i (
      .clk(clk), .rst(rst), .start_valid(sv32), .start_ready(rdy32),
      .state_in(sin32), .key_in(key32), .key_round(kr32), .key_phase(kp32),
      .busy(busy32), .done(done32), .state_out(sout32));

   arx_perm_core #(.WORD_W(64)) dut64_i (
      .clk(clk), .rst(rst), .start_valid(sv64), .start_ready(rdy64),
      .state_in(sin64), .key_in(key64), .key_round(kr64), .key_phase(kp64),
      .busy(busy64), .done(done64), .state_out(sout64));

   // key supplier: table entry chosen by the requested selection index
   always_comb begin
      for (int i = 0; i < 16; i++) begin
         key32[i*32 +: 32] = (kr32 < 4'd10) ? kt[kr32][i][31:0] : 32'h0;
         key64[i*64 +: 64] = (kr64 < 4'd10) ? kt[kr64][i] : 64'h0;
      end
   end

   // ---------------- reference model ----------------
   function automatic logic [63:0] msk(input int w);
      return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
   endfunction

   function automatic logic [63:0] rotr(input logic [63:0] x, input int n, input int w);
      logic [63:0] y;
      y = x & msk(w);
      return ((y >> n) | (y << (w - n))) & msk(w);
   endfunction

   function automatic st_t g_ref(input st_t v, input int ia, input int ib, input int ic,
                                 input int id, input logic [63:0] k0, input logic [63:0] k1,
                                 input int w);
      int ra, rb, rc, rd;
      ra = (w == 64) ? 32 : 16;  rb = (w == 64) ? 25 : 12;
      rc = (w == 64) ? 16 : 8;   rd = (w == 64) ? 11 : 7;
      v[ia] = (v[ia] + v[ib] + k0) & msk(w);
      v[id] = rotr(v[id] ^ v[ia], ra, w);
      v[ic] = (v[ic] + v[id]) & msk(w);
      v[ib] = rotr(v[ib] ^ v[ic], rb, w);
      v[ia] = (v[ia] + v[ib] + k1) & msk(w);
      v[id] = rotr(v[id] ^ v[ia], rc, w);
      v[ic] = (v[ic] + v[id]) & msk(w);
      v[ib] = rotr(v[ib] ^ v[ic], rd, w);
      return v;
   endfunction

   function automatic st_t col_ref(input st_t v, input st_t k, input int base, input int w);
      for (int j = 0; j < 4; j++)
         v = g_ref(v, j, 4 + j, 8 + j, 12 + j, k[base + 2*j], k[base + 2*j + 1], w);
      return v;
   endfunction

   function automatic st_t diag_direct(input st_t v, input st_t k, input int w);
      for (int j = 0; j < 4; j++)
         v = g_ref(v, j, 4 + (j+1)%4, 8 + (j+2)%4, 12 + (j+3)%4, k[8 + 2*j], k[9 + 2*j], w);
      return v;
   endfunction

   function automatic st_t rows_shift(input st_t v, input bit left);
      st_t o;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            o[4*r + c] = left ? v[4*r + (c + r) % 4] : v[4*r + (c + 4 - r) % 4];
      return o;
   endfunction

   function automatic st_t diag_by_rot(input st_t v, input st_t k, input int w);
      return rows_shift(col_ref(rows_shift(v, 1'b1), k, 8, w), 1'b0);
   endfunction

   function automatic st_t full_ref(input st_t v, input int w);
      int nr;
      nr = (w == 64) ? 16 : 14;
      for (int r = 0; r < nr; r++) begin
         v = col_ref(v, kt[r % 10], 0, w);
         v = diag_direct(v, kt[r % 10], w);
      end
      return v;
   endfunction

   function automatic st_t rand_state(input int w);
      st_t v;
      for (int i = 0; i < 16; i++) v[i] = {$urandom(), $urandom()} & msk(w);
      return v;
   endfunction

   // ---------------- checking helpers ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_state(input string req, input string what, input st_t act, input st_t exp);
      int bad;
      bad = -1;
      for (int i = 15; i >= 0; i--) if (act[i] !== exp[i]) bad = i;
      if (bad < 0) check(1'b1, req, what, 64'h0, 64'h0);
      else         check(1'b0, req, {what, $sformatf(" word %0d", bad)}, act[bad], exp[bad]);
   endtask

   function automatic st_t read_out(input bit use64);
      st_t v;
      for (int i = 0; i < 16; i++) v[i] = use64 ? sout64[i*64 +: 64] : {32'h0, sout32[i*32 +: 32]};
      return v;
   endfunction

   task automatic drive_state(input bit use64, input st_t v);
      for (int i = 0; i < 16; i++) begin
         if (use64) sin64[i*64 +: 64] = v[i];
         else       sin32[i*32 +: 32] = v[i][31:0];
      end
   endtask

   // run one hash; inject_at >= 0 raises start_valid for one cycle mid-run
   task automatic run_hash(input bit use64, input st_t vin, input int inject_at, input string tag);
      int   cyc, seq_err, rdy_err, nr, w;
      st_t  exp_v, got, other;
      w  = use64 ? 64 : 32;
      nr = use64 ? 16 : 14;
      exp_v = full_ref(vin, w);
      other = rand_state(w);
      @(negedge clk);
      drive_state(use64, vin);
      if (use64) sv64 = 1'b1; else sv32 = 1'b1;
      @(negedge clk);
      sv32 = 1'b0; sv64 = 1'b0;
      cyc = 0; seq_err = 0; rdy_err = 0;
      while (1) begin
         if ((use64 ? kr64 : kr32) != 4'((cyc / 2) % 10) || (use64 ? kp64 : kp32) != 1'(cyc % 2))
            seq_err++;
         if (use64 ? rdy64 : rdy32) rdy_err++;
         if (cyc == inject_at) begin
            drive_state(use64, other);
            if (use64) sv64 = 1'b1; else sv32 = 1'b1;
         end else begin
            sv32 = 1'b0; sv64 = 1'b0;
         end
         @(negedge clk);
         cyc++;
         if (use64 ? done64 : done32) break;
         if (cyc > 200) break;
      end
      sv32 = 1'b0; sv64 = 1'b0;
      got = read_out(use64);
      if (inject_at >= 0) check_state("R9", {tag, " start while busy ignored"}, got, exp_v);
      else if (use64)     check_state("R10", {tag, " 64-bit result"}, got, exp_v);
      else                check_state("R5", {tag, " R3 R4 32-bit result"}, got, exp_v);
      check(cyc == 2 * nr, use64 ? "R10" : "R6", {tag, " cycles to done"}, 64'(cyc), 64'(2 * nr));
      check(seq_err == 0, "R7", {tag, " key request sequence errors"}, 64'(seq_err), 64'h0);
      check(rdy_err == 0, "R2", {tag, " ready high while busy"}, 64'(rdy_err), 64'h0);
      // done must drop and the result must hold
      @(negedge clk);
      check((use64 ? done64 : done32) == 1'b0, "R8", {tag, " done single cycle"},
            64'(use64 ? done64 : done32), 64'h0);
      repeat (4) @(negedge clk);
      check_state("R8", {tag, " result held while idle"}, read_out(use64), exp_v);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #2ms;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      st_t v, a, b, ones;
      void'($urandom(32'hA5C3_1E07));
      for (int r = 0; r < 10; r++)
         for (int i = 0; i < 16; i++) kt[r][i] = {$urandom(), $urandom()};
      rst = 1'b1; sv32 = 1'b0; sv64 = 1'b0; sin32 = '0; sin64 = '0;
      repeat (3) @(negedge clk);
      check(rdy32 && rdy64, "R1", "ready in reset", 64'({rdy32, rdy64}), 64'h3);
      check(!busy32 && !busy64, "R1", "busy in reset", 64'({busy32, busy64}), 64'h0);
      check(!done32 && !done64, "R1", "done in reset", 64'({done32, done64}), 64'h0);
      check(kr32 == 4'd0 && !kp32, "R1", "key request in reset", 64'({kr32, kp32}), 64'h0);
      rst = 1'b0;
      @(negedge clk);
      check(rdy32 && !busy32 && !done32, "R1", "idle after reset release",
            64'({rdy32, busy32, done32}), 64'h4);

      // model self-consistency: direct diagonal against row-rotation method
      for (int t = 0; t < 4; t++) begin
         int w;
         w = (t < 2) ? 32 : 64;
         v = col_ref(rand_state(w), kt[t], 0, w);
         a = diag_direct(v, kt[t], w);
         b = diag_by_rot(v, kt[t], w);
         check_state("R4", $sformatf("diagonal methods agree w=%0d", w), b, a);
      end

      // directed corners
      for (int i = 0; i < 16; i++) begin v[i] = 64'h0; ones[i] = 64'hFFFF_FFFF_FFFF_FFFF; end
      run_hash(1'b0, v, -1, "zero32");
      for (int i = 0; i < 16; i++) ones[i] = 64'h0000_0000_FFFF_FFFF;
      run_hash(1'b0, ones, -1, "ones32");
      for (int i = 0; i < 16; i++) v[i] = 64'(i);
      run_hash(1'b0, v, -1, "index32");
      // random runs
      for (int t = 0; t < 3; t++) run_hash(1'b0, rand_state(32), -1, $sformatf("rand32_%0d", t));
      for (int i = 0; i < 16; i++) v[i] = 64'h0;
      run_hash(1'b1, v, -1, "zero64");
      for (int t = 0; t < 2; t++) run_hash(1'b1, rand_state(64), -1, $sformatf("rand64_%0d", t));
      // start request while busy: in a column cycle, in a diagonal cycle, in round ten
      run_hash(1'b0, rand_state(32), 4, "inject32_col");
      run_hash(1'b0, rand_state(32), 7, "inject32_diag");
      run_hash(1'b1, rand_state(64), 21, "inject64_r10");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule